// File: doc/BRIEF.md
# UART Receive Status and Interrupt Core

This block holds the receive-side character store of one UART channel together with the logic that turns its fill and error state into a line status byte and a receive-data-available interrupt. Each stored character carries its own parity, framing and break flags, so the error bits in the status byte always describe the character the host will read next. A separate summary bit tells the host that some character still waiting in the store carries an error, and an overrun bit records characters that were lost.

The host chooses between two store modes. In queue mode the store is `DEPTH` entries deep and the interrupt follows the fill against one of four trigger levels. In single-register mode the store holds exactly one character. A four-bit interrupt mask selects the sources, and when queue mode is on and all four mask bits are clear the block reports polled operation. A fill-state machine with four states drives data-ready and the level indication. It starts in FILL_EMPTY. It moves to FILL_BELOW when the fill is nonzero and under the trigger. It moves to FILL_LEVEL when the fill is at or above the trigger but below capacity. It moves to FILL_FULL when the fill equals capacity. Every clock it chooses its next state from the next fill, so any state can follow any other, and a flush always leads to FILL_EMPTY.

Top module: `rxstat_top`

## Requirements
- R1: A character presented with `rx_valid` while the store is not full, or while a data read is taken in the same cycle, is stored, and `line_status[0]` (data ready) is 1 from the following cycle. `line_status[0]` returns to 0 only when the store becomes empty.
- R2: `rd_data` shows the oldest stored character, in arrival order, or 0 when the store is empty. A `host_rd_data` pulse removes that character.
- R3: `line_status[1]` (overrun) sets when `rx_valid` arrives while the store is full and no read is taken, and also on `ovr_strobe`. The arriving character is discarded.
- R4: A `host_rd_status` pulse clears `line_status[1]` in the next cycle, unless a new overrun occurs in that same cycle.
- R5: `line_status[2]` is the parity flag, `line_status[3]` the framing flag and `line_status[4]` the break flag of the oldest stored character. All three are 0 when the store is empty.
- R6: `line_status[7]` is 1 while at least one stored character has any error flag set.
- R7: `line_status[5]` equals `tx_fifo_empty`. `line_status[6]` equals `tx_fifo_empty` AND `tx_shift_empty`.
- R8: `rda_irq` is 1 exactly when mask bit 0 is set and the fill is at or above the trigger. In queue mode the trigger for select 0, 1, 2 and 3 is 1, DEPTH/4, DEPTH/2 and DEPTH-DEPTH/8 (1, 16, 32 and 56 by default). In single-register mode the trigger is 1.
- R9: With `cfg_fifo_en`=0 (the reset mode) the store holds one character. A second arrival is an overrun, and data ready clears when that character is read.
- R10: `polled_mode` is 1 exactly when queue mode is on and all four mask bits are 0.
- R11: After reset the block is in single-register mode with the mask and trigger select at 0, the store empty, overrun clear and `rda_irq` at 0.
- R12: A configuration write that changes the store mode empties the store and clears the error count. Characters arriving or read in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error of the character |
| rx_ferr | input | 1 | Framing error of the character |
| rx_brk | input | 1 | Break indication of the character |
| ovr_strobe | input | 1 | External overrun strobe |
| tx_fifo_empty | input | 1 | Transmit queue is empty |
| tx_shift_empty | input | 1 | Transmit shifter is empty |
| host_rd_data | input | 1 | Host reads and removes the oldest character |
| host_rd_status | input | 1 | Host reads the line status |
| cfg_we | input | 1 | Write the store mode and trigger select |
| cfg_fifo_en | input | 1 | 1 selects queue mode, 0 selects single-register mode |
| cfg_trig_sel | input | 2 | Trigger level select |
| ie_we | input | 1 | Write the interrupt mask |
| ie_wdata | input | 4 | Interrupt mask; bit 0 enables receive data available |
| rd_data | output | 8 | Oldest stored character |
| line_status | output | 8 | Line status byte |
| rda_irq | output | 1 | Receive data available interrupt |
| polled_mode | output | 1 | Polled operation indication |

## Verification
Every strobe and register write is sampled on one rising edge. Its effect on `line_status`, `rd_data`, `rda_irq` and `polled_mode` is due in the cycle that follows, because each of these is decoded straight from registers. The transmit bits are the only exception: they follow `tx_fifo_empty` and `tx_shift_empty` in the same cycle. The bench drives inputs 2 ns after a rising edge and updates its queue model on that same rising edge. It compares every output on the falling edge, so both the model and the design have settled after exactly one edge. The directed checks read the ports 3 ns after the edge that took the stimulus.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam int unsigned DATA_W = 8;

    // One stored character with the error flags that belong to it
    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [1:0] {
        FILL_EMPTY,
        FILL_BELOW,
        FILL_LEVEL,
        FILL_FULL
    } fill_state_t;

    // Trigger level for a select code at a given store depth
    function automatic int unsigned trig_level(int unsigned depth, logic [1:0] sel);
        int unsigned lvl;
        case (sel)
            2'd0:    lvl = 1;
            2'd1:    lvl = depth / 4;
            2'd2:    lvl = depth / 2;
            default: lvl = depth - depth / 8;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/rxs_store.sv
module rxs_store
    import rxs_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  rx_entry_t     wr_entry,
    output rx_entry_t     head,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nxt
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    assign do_push = push && !flush;
    assign do_pop  = pop && !flush;
    assign head    = mem[rd_ptr];

    always_comb begin
        count_nxt = count;
        if (flush) begin
            count_nxt = '0;
        end else begin
            case ({do_push, do_pop})
                2'b10:   count_nxt = count + CW'(1);
                2'b01:   count_nxt = count - CW'(1);
                default: count_nxt = count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            count <= count_nxt;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
                if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wr_entry;
    end

endmodule

// File: rtl/rxs_errtally.sv
module rxs_errtally #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic push,
    input  logic push_err,
    input  logic pop,
    input  logic head_err,
    output logic any_err
);

    logic [CW-1:0] err_cnt;
    logic          inc;
    logic          dec;

    assign inc     = push && push_err && !flush;
    assign dec     = pop && head_err && !flush;
    assign any_err = (err_cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_cnt <= '0;
        end else if (flush) begin
            err_cnt <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   err_cnt <= err_cnt + CW'(1);
                2'b01:   err_cnt <= err_cnt - CW'(1);
                default: err_cnt <= err_cnt;
            endcase
        end
    end

endmodule

// File: rtl/rxs_fsm.sv
module rxs_fsm
    import rxs_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count_nxt,
    input  logic [CW-1:0] cap_nxt,
    input  logic [CW-1:0] trig_nxt,
    output logic          data_ready,
    output logic          level_hit
);

    fill_state_t state_q;
    fill_state_t state_d;

    always_comb begin
        if (count_nxt == '0)           state_d = FILL_EMPTY;
        else if (count_nxt >= cap_nxt) state_d = FILL_FULL;
        else if (count_nxt >= trig_nxt) state_d = FILL_LEVEL;
        else                           state_d = FILL_BELOW;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FILL_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            FILL_EMPTY: begin data_ready = 1'b0; level_hit = 1'b0; end
            FILL_BELOW: begin data_ready = 1'b1; level_hit = 1'b0; end
            FILL_LEVEL: begin data_ready = 1'b1; level_hit = 1'b1; end
            FILL_FULL:  begin data_ready = 1'b1; level_hit = 1'b1; end
            default:    begin data_ready = 1'b0; level_hit = 1'b0; end
        endcase
    end

endmodule

// File: rtl/rxstat_top.sv
module rxstat_top
    import rxs_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_perr,
    input  logic       rx_ferr,
    input  logic       rx_brk,
    input  logic       ovr_strobe,
    input  logic       tx_fifo_empty,
    input  logic       tx_shift_empty,
    input  logic       host_rd_data,
    input  logic       host_rd_status,
    input  logic       cfg_we,
    input  logic       cfg_fifo_en,
    input  logic [1:0] cfg_trig_sel,
    input  logic       ie_we,
    input  logic [3:0] ie_wdata,
    output logic [7:0] rd_data,
    output logic [7:0] line_status,
    output logic       rda_irq,
    output logic       polled_mode
);

    localparam logic [CW-1:0] CAP_Q   = CW'(DEPTH);
    localparam logic [CW-1:0] CAP_ONE = CW'(1);

    logic          fifo_en;
    logic [1:0]    trig_sel;
    logic [3:0]    ie_q;
    logic          ovr_q;

    logic          en_nxt;
    logic [1:0]    sel_nxt;
    logic [CW-1:0] cap;
    logic [CW-1:0] cap_nxt;
    logic [CW-1:0] trig_nxt;
    logic [CW-1:0] count;
    logic [CW-1:0] count_nxt;
    logic          full;
    logic          flush;
    logic          push;
    logic          pop;
    logic          ovr_hit;
    logic          data_ready;
    logic          level_hit;
    logic          any_err;
    rx_entry_t     wr_entry;
    rx_entry_t     head;

    assign en_nxt   = cfg_we ? cfg_fifo_en : fifo_en;
    assign sel_nxt  = cfg_we ? cfg_trig_sel : trig_sel;
    assign cap      = fifo_en ? CAP_Q : CAP_ONE;
    assign cap_nxt  = en_nxt ? CAP_Q : CAP_ONE;
    assign trig_nxt = en_nxt ? CW'(trig_level(DEPTH, sel_nxt)) : CAP_ONE;

    assign full     = (count >= cap);
    assign flush    = cfg_we && (cfg_fifo_en != fifo_en);
    assign pop      = host_rd_data && (count != '0);
    assign push     = rx_valid && (!full || pop);
    assign ovr_hit  = rx_valid && full && !pop;

    assign wr_entry = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_data};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_en  <= 1'b0;
            trig_sel <= 2'd0;
            ie_q     <= 4'd0;
            ovr_q    <= 1'b0;
        end else begin
            fifo_en  <= en_nxt;
            trig_sel <= sel_nxt;
            if (ie_we) ie_q <= ie_wdata;
            if (ovr_hit || ovr_strobe) ovr_q <= 1'b1;
            else if (host_rd_status)   ovr_q <= 1'b0;
        end
    end

    rxs_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push),
        .pop       (pop),
        .wr_entry  (wr_entry),
        .head      (head),
        .count     (count),
        .count_nxt (count_nxt)
    );

    rxs_errtally #(.DEPTH(DEPTH)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push     (push),
        .push_err (rx_perr || rx_ferr || rx_brk),
        .pop      (pop),
        .head_err (head.perr || head.ferr || head.brk),
        .any_err  (any_err)
    );

    rxs_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_nxt  (count_nxt),
        .cap_nxt    (cap_nxt),
        .trig_nxt   (trig_nxt),
        .data_ready (data_ready),
        .level_hit  (level_hit)
    );

    assign rd_data     = data_ready ? head.data : 8'd0;
    assign line_status = {any_err,
                          tx_fifo_empty && tx_shift_empty,
                          tx_fifo_empty,
                          data_ready && head.brk,
                          data_ready && head.ferr,
                          data_ready && head.perr,
                          ovr_q,
                          data_ready};
    assign rda_irq     = ie_q[0] && level_hit;
    assign polled_mode = fifo_en && (ie_q == 4'd0);

endmodule

// File: rtl/rxstat_chk.sv
module rxstat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       ovr_strobe,
    input logic       host_rd_status,
    input logic       cfg_we,
    input logic [7:0] line_status,
    input logic       rda_irq,
    input logic       polled_mode
);

    // R1
    data_ready_after_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_we) |=> line_status[0]);

    // R3
    overrun_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_strobe |=> line_status[1]);

    // R4
    overrun_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_status && !ovr_strobe && !rx_valid) |=> !line_status[1]);

    // R8
    irq_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rda_irq |-> line_status[0]);

    // R10
    polled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        polled_mode |-> !rda_irq);

    // R6
    head_err_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_status[4:2] != 3'b000) |-> line_status[7]);

    // R7
    tx_bits_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_status[6] |-> line_status[5]);

endmodule

bind rxstat_top rxstat_chk u_rxstat_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_valid       (rx_valid),
    .ovr_strobe     (ovr_strobe),
    .host_rd_status (host_rd_status),
    .cfg_we         (cfg_we),
    .line_status    (line_status),
    .rda_irq        (rda_irq),
    .polled_mode    (polled_mode)
);

// File: tb/test_rxstat_top.sv
`timescale 1ns/1ps
module test_rxstat_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_valid, rx_perr, rx_ferr, rx_brk, ovr_strobe;
    logic [7:0] rx_data;
    logic       tx_fifo_empty, tx_shift_empty;
    logic       host_rd_data, host_rd_status;
    logic       cfg_we, cfg_fifo_en, ie_we;
    logic [1:0] cfg_trig_sel;
    logic [3:0] ie_wdata;
    logic [7:0] rd_data, line_status;
    logic       rda_irq, polled_mode;

    int n_cmp  = 0;
    int n_fail = 0;
    bit cmp_on = 0;

    // reference model state
    bit [10:0] q[$];
    bit        m_en;
    bit [1:0]  m_sel;
    bit [3:0]  m_ie;
    bit        m_ovr;

    always #4 clk = ~clk;

    rxstat_top i_rxstat_top (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
        .ovr_strobe(ovr_strobe), .tx_fifo_empty(tx_fifo_empty),
        .tx_shift_empty(tx_shift_empty), .host_rd_data(host_rd_data),
        .host_rd_status(host_rd_status), .cfg_we(cfg_we),
        .cfg_fifo_en(cfg_fifo_en), .cfg_trig_sel(cfg_trig_sel),
        .ie_we(ie_we), .ie_wdata(ie_wdata), .rd_data(rd_data),
        .line_status(line_status), .rda_irq(rda_irq), .polled_mode(polled_mode)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    function automatic int m_trig();
        if (!m_en) return 1;
        case (m_sel)
            2'd0: return 1;
            2'd1: return 16;
            2'd2: return 32;
            default: return 56;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_en = 0; m_sel = 0; m_ie = 0; m_ovr = 0;
        end else begin
            int  cap;
            bit  full, pop, flush;
            cap   = m_en ? 64 : 1;
            full  = q.size() >= cap;
            pop   = host_rd_data && q.size() > 0;
            flush = cfg_we && (cfg_fifo_en != m_en);
            if ((rx_valid && full && !pop) || ovr_strobe) m_ovr = 1;
            else if (host_rd_status) m_ovr = 0;
            if (flush) q.delete();
            else begin
                if (pop) void'(q.pop_front());
                if (rx_valid && (!full || pop))
                    q.push_back({rx_brk, rx_ferr, rx_perr, rx_data});
            end
            if (cfg_we) begin m_en = cfg_fifo_en; m_sel = cfg_trig_sel; end
            if (ie_we) m_ie = ie_wdata;
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            bit [10:0] h;
            bit        anyerr;
            h = (q.size() > 0) ? q[0] : 11'd0;
            anyerr = 0;
            foreach (q[i]) if (q[i][10:8] != 3'b000) anyerr = 1;
            check("R1 data ready", line_status[0], q.size() > 0);
            check("R2 read data", rd_data, h[7:0]);
            check("R3 overrun", line_status[1], m_ovr);
            check("R5 head errors", line_status[4:2], h[10:8]);
            check("R6 any error", line_status[7], anyerr);
            check("R7 tx bits", line_status[6:5],
                  {tx_fifo_empty && tx_shift_empty, tx_fifo_empty});
            check("R8 irq", rda_irq, m_ie[0] && (q.size() >= m_trig()));
            check("R10 polled", polled_mode, m_en && (m_ie == 0));
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
        rx_valid = 0; ovr_strobe = 0; host_rd_data = 0; host_rd_status = 0;
        cfg_we = 0; ie_we = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
    endtask

    task automatic send(logic [7:0] d, logic [2:0] e);
        rx_valid = 1; rx_data = d; {rx_brk, rx_ferr, rx_perr} = e;
        tick();
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; rx_valid = 0; rx_data = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
        ovr_strobe = 0; tx_fifo_empty = 1; tx_shift_empty = 1; host_rd_data = 0;
        host_rd_status = 0; cfg_we = 0; cfg_fifo_en = 0; cfg_trig_sel = 0;
        ie_we = 0; ie_wdata = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        #1;
        // R11 reset state
        check("R11 status", line_status, 8'h60);
        check("R11 irq", rda_irq, 0);
        check("R11 polled", polled_mode, 0);
        cmp_on = 1;
        tick();

        // R9 single-register mode
        ie_we = 1; ie_wdata = 4'h1; tick();
        send(8'hA5, 3'b001); #1;
        check("R9 held char", rd_data, 8'hA5);
        check("R9 irq at one", rda_irq, 1);
        send(8'h3C, 3'b000); #1;
        check("R9 second is overrun", line_status[1], 1);
        check("R9 first kept", rd_data, 8'hA5);
        host_rd_status = 1; tick(); #1;
        check("R4 overrun cleared", line_status[1], 0);
        host_rd_data = 1; tick(); #1;
        check("R9 ready cleared", line_status[0], 0);

        // R12 flush on mode change
        send(8'h11, 3'b100);
        cfg_we = 1; cfg_fifo_en = 1; cfg_trig_sel = 2'd1; tick(); #1;
        check("R12 store emptied", line_status[0], 0);
        check("R12 errors cleared", line_status[7], 0);

        // queue fill across trigger 16 with errors sprinkled
        for (int i = 0; i < 20; i++) begin
            send(8'(i + 8'h40), (i % 5 == 0) ? 3'b010 : 3'b000);
            #1;
            if (i == 14) check("R8 below 16", rda_irq, 0);
            if (i == 15) check("R8 at 16", rda_irq, 1);
        end
        for (int i = 0; i < 5; i++) begin host_rd_data = 1; tick(); end
        #1 check("R8 dropped under 16", rda_irq, 0);

        // trigger 56, fill to full and overflow
        cfg_we = 1; cfg_fifo_en = 1; cfg_trig_sel = 2'd3; tick();
        for (int i = 0; i < 52; i++) send(8'(i), 3'b000);
        #1 check("R8 at 56", rda_irq, 1);
        send(8'hEE, 3'b000);
        send(8'hEF, 3'b000); #1;
        check("R3 full overrun", line_status[1], 1);
        for (int i = 0; i < 64; i++) begin host_rd_data = 1; tick(); end
        #1 check("R1 empty after drain", line_status[0], 0);

        // R10 polled mode
        ie_we = 1; ie_wdata = 4'h0; tick(); #1;
        check("R10 polled on", polled_mode, 1);
        ie_we = 1; ie_wdata = 4'h4; tick(); #1;
        check("R10 polled off", polled_mode, 0);

        // mixed random traffic
        for (int i = 0; i < 4000; i++) begin
            rx_valid       = ($urandom % 10) < 4;
            rx_data        = 8'($urandom);
            {rx_brk, rx_ferr, rx_perr} = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
            host_rd_data   = ($urandom % 10) < 4;
            host_rd_status = ($urandom % 10) == 0;
            ovr_strobe     = ($urandom % 40) == 0;
            tx_fifo_empty  = 1'($urandom);
            tx_shift_empty = 1'($urandom);
            if (($urandom % 60) == 0) begin
                cfg_we = 1; cfg_fifo_en = ($urandom % 4) != 0; cfg_trig_sel = 2'($urandom);
            end
            if (($urandom % 40) == 0) begin ie_we = 1; ie_wdata = 4'($urandom); end
            @(posedge clk);
            #2;
            rx_valid = 0; ovr_strobe = 0; host_rd_data = 0; host_rd_status = 0;
            cfg_we = 0; ie_we = 0;
        end

        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule